// File: doc/BRIEF.md
# D-Channel Contention Access Controller

This block decides when an HDLC-style serial transmitter may place its D-channel bits on a shared, open-drain time-division bus. The attached layer-1 device reports whether the D channel is free, and the block takes that report from one of two sources. The first is a busy bit inside the command/indicate field received on bus channel 2, where a high value means a collision or busy line. The second is a dedicated grant pin, where a high value means free. A configuration input picks the source.

A pending frame waits until the channel is reported free, and then it is sent. If a collision is reported while the frame is still in one of its first two buffers, the block stops the frame at once and releases the data line for the rest of the bus frame. It then waits for the channel to be free again and tells the transmitter to restart the frame from its first bit. A collision that comes later drops the frame and raises a sticky error flag.

Every state change is decided on the frame-boundary strobe, once per bus frame.

Top module: `dca_access_ctrl`

## Requirements
- R1: After reset the block is idle: `txGo`, `aborting`, `txRestart` and `dropErr` are 0, and `dOut` is 1.
- R2: `txGo` and `aborting` change only in the clock cycle after a cycle in which `frameTick` was high.
- R3: With `useGrant`=0 the channel counts as free when bit 4 of `ciCh2` is 0, and the other bits are ignored. With `useGrant`=1 it counts as free when `grantIn` is 1.
- R4: While a request is pending (`txReq` high, sampled on a frame tick when idle), the first frame tick that sees a free channel starts transmission (`txGo`=1).
- R5: `dOut` follows `txBit` while `txGo` is 1 and is 1 (released) at all other times.
- R6: A frame tick that sees a busy channel during transmission, when fewer than 2 `bufAdvance` pulses have arrived since the frame started, aborts the frame. `aborting` is then 1 for exactly one frame, with `txGo`=0.
- R7: After an abort, the block waits for a frame tick that sees a free channel, then resumes transmission and pulses `txRestart` for one cycle, in the same cycle that `txGo` rises.
- R8: A frame tick that sees a busy channel during transmission after 2 or more `bufAdvance` pulses drops the frame. The block returns to idle with no retry and sets `dropErr`.
- R9: `dropErr` stays set until the next request is accepted from idle, and it is cleared then.
- R10: A `txDone` pulse during transmission ends the frame at the next frame tick, including the cycle of the tick itself. It takes precedence over a busy indication at that tick.
- R11: The buffer count restarts from zero at every start and restart, so a retried frame again has two buffers of retry protection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frameTick | input | 1 | One-cycle strobe at each bus frame boundary |
| useGrant | input | 1 | Source select: 0 = C/I busy bit, 1 = grant pin |
| ciCh2 | input | CI_W | Received command/indicate field of bus channel 2 |
| grantIn | input | 1 | Grant pin, high when the D channel is free |
| txReq | input | 1 | Transmitter has a frame pending |
| bufAdvance | input | 1 | Pulse: transmitter moved on to the next buffer of the frame |
| txDone | input | 1 | Pulse: transmitter sent the last bit of the frame |
| txBit | input | 1 | Serial D-channel data from the transmitter |
| dOut | output | 1 | D-channel data toward the open-drain driver (1 = released) |
| txGo | output | 1 | Transmission permitted |
| txRestart | output | 1 | Pulse: rewind the frame to its start |
| aborting | output | 1 | Frame aborted; line released for this frame |
| dropErr | output | 1 | Sticky: frame dropped after a late collision |

## Verification
The assertions take for granted that `frameTick` is a single-cycle strobe and that `bufAdvance` and `txDone` are one-cycle pulses. They also assume the transmitter releases `txReq` once its frame is accepted or dropped, so that the sticky error is not cleared straight away. The directed stimulus keeps to this by raising every pulse for exactly one clock and lowering the request after each start. The random phase draws the pulses independently each cycle. A behavioural model in the bench covers the overlaps that random draws produce, such as a done pulse on the tick itself or a collision and a done pulse at the same tick.

// File: rtl/dca_pkg.sv
package dca_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_FREE,
    ST_TRANSMIT,
    ST_ABORT,
    ST_RETRY_WAIT
  } dcaState_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic clrBuf;
    logic setErr;
    logic clrErr;
    logic restart;
  } dcaStrobe_t;

endpackage

// File: rtl/dca_datapath.sv
module dca_datapath
  import dca_pkg::*;
#(
  parameter int CI_W       = 6,
  parameter int FREE_BIT   = 4,
  parameter int RETRY_BUFS = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            frameTick,
  input  logic            useGrant,
  input  logic [CI_W-1:0] ciCh2,
  input  logic            grantIn,
  input  logic            txDone,
  input  logic            bufAdvance,
  input  logic            txBit,
  input  logic            inTx,
  input  dcaStrobe_t      strobe,
  output logic            chanFree,
  output logic            retryOk,
  output logic            donePend,
  output logic            dOut,
  output logic            dropErr,
  output logic            txRestart
);

  localparam int CNT_W = $clog2(RETRY_BUFS + 1);
  localparam logic [CNT_W-1:0] BUF_LIM = CNT_W'(RETRY_BUFS);

  logic [CNT_W-1:0] bufCnt;
  logic             doneLatch;

  // access source: busy bit in C/I field (high = collision) or grant pin
  generate
    if (FREE_BIT < CI_W) begin : g_src
      assign chanFree = useGrant ? grantIn : ~ciCh2[FREE_BIT];
    end else begin : g_grantOnly
      assign chanFree = grantIn;
    end
  endgenerate

  assign retryOk  = (bufCnt < BUF_LIM);
  assign donePend = doneLatch | (txDone & inTx);
  assign dOut     = inTx ? txBit : 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufCnt    <= '0;
      doneLatch <= 1'b0;
      dropErr   <= 1'b0;
      txRestart <= 1'b0;
    end else begin
      if (strobe.clrBuf)
        bufCnt <= '0;
      else if (bufAdvance && inTx && retryOk)
        bufCnt <= bufCnt + 1'b1;

      doneLatch <= frameTick ? 1'b0 : donePend;

      if (strobe.setErr)
        dropErr <= 1'b1;
      else if (strobe.clrErr)
        dropErr <= 1'b0;

      txRestart <= strobe.restart;
    end
  end

endmodule

// File: rtl/dca_control.sv
module dca_control
  import dca_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameTick,
  input  logic       txReq,
  input  logic       chanFree,
  input  logic       retryOk,
  input  logic       donePend,
  output dcaStrobe_t strobe,
  output logic       inTx,
  output logic       aborting
);

  dcaState_e state, stateNxt;

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    if (frameTick) begin
      unique case (state)
        ST_IDLE: if (txReq) begin
          stateNxt      = ST_WAIT_FREE;
          strobe.clrErr = 1'b1;
        end
        ST_WAIT_FREE: if (chanFree) begin
          stateNxt      = ST_TRANSMIT;
          strobe.clrBuf = 1'b1;
        end
        ST_TRANSMIT: begin
          if (donePend)
            stateNxt = ST_IDLE;
          else if (!chanFree) begin
            if (retryOk)
              stateNxt = ST_ABORT;
            else begin
              stateNxt      = ST_IDLE;
              strobe.setErr = 1'b1;
            end
          end
        end
        ST_ABORT: stateNxt = ST_RETRY_WAIT;
        ST_RETRY_WAIT: if (chanFree) begin
          stateNxt       = ST_TRANSMIT;
          strobe.clrBuf  = 1'b1;
          strobe.restart = 1'b1;
        end
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  assign inTx     = (state == ST_TRANSMIT);
  assign aborting = (state == ST_ABORT);

endmodule

// File: rtl/dca_access_ctrl.sv
module dca_access_ctrl
  import dca_pkg::*;
#(
  parameter int CI_W       = 6,
  parameter int FREE_BIT   = 4,
  parameter int RETRY_BUFS = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            frameTick,
  input  logic            useGrant,
  input  logic [CI_W-1:0] ciCh2,
  input  logic            grantIn,
  input  logic            txReq,
  input  logic            bufAdvance,
  input  logic            txDone,
  input  logic            txBit,
  output logic            dOut,
  output logic            txGo,
  output logic            txRestart,
  output logic            aborting,
  output logic            dropErr
);

  dcaStrobe_t strobe;
  logic chanFree, retryOk, donePend, inTx;

  dca_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .frameTick (frameTick),
    .txReq     (txReq),
    .chanFree  (chanFree),
    .retryOk   (retryOk),
    .donePend  (donePend),
    .strobe    (strobe),
    .inTx      (inTx),
    .aborting  (aborting)
  );

  dca_datapath #(
    .CI_W       (CI_W),
    .FREE_BIT   (FREE_BIT),
    .RETRY_BUFS (RETRY_BUFS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .frameTick  (frameTick),
    .useGrant   (useGrant),
    .ciCh2      (ciCh2),
    .grantIn    (grantIn),
    .txDone     (txDone),
    .bufAdvance (bufAdvance),
    .txBit      (txBit),
    .inTx       (inTx),
    .strobe     (strobe),
    .chanFree   (chanFree),
    .retryOk    (retryOk),
    .donePend   (donePend),
    .dOut       (dOut),
    .dropErr    (dropErr),
    .txRestart  (txRestart)
  );

  assign txGo = inTx;

endmodule

// File: rtl/dca_access_ctrl_chk.sv
module dca_access_ctrl_chk (
  input logic clk,
  input logic rstN,
  input logic frameTick,
  input logic dOut,
  input logic txGo,
  input logic txRestart,
  input logic aborting,
  input logic dropErr
);

  a_r2_go_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    !frameTick |=> ($stable(txGo) && $stable(aborting)));

  a_r5_released_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !txGo |-> dOut);

  a_r6_abort_excludes_go: assert property (@(posedge clk) disable iff (!rstN)
    aborting |-> !txGo);

  a_r6_abort_from_tx: assert property (@(posedge clk) disable iff (!rstN)
    $rose(aborting) |-> $past(txGo));

  a_r7_restart_with_go: assert property (@(posedge clk) disable iff (!rstN)
    txRestart |-> txGo);

  a_r7_restart_single: assert property (@(posedge clk) disable iff (!rstN)
    txRestart |=> !txRestart);

  a_r8_drop_to_idle: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dropErr) |-> (!txGo && !aborting));

endmodule

bind dca_access_ctrl dca_access_ctrl_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .frameTick (frameTick),
  .dOut      (dOut),
  .txGo      (txGo),
  .txRestart (txRestart),
  .aborting  (aborting),
  .dropErr   (dropErr)
);

// File: tb/dca_access_ctrl_tb.sv
`timescale 1ns/1ps
module dca_access_ctrl_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameTick = 1'b0;
  logic useGrant = 1'b0;
  logic [5:0] ciCh2 = 6'b010000;
  logic grantIn = 1'b0;
  logic txReq = 1'b0;
  logic bufAdvance = 1'b0;
  logic txDone = 1'b0;
  logic txBit = 1'b0;
  logic dOut, txGo, txRestart, aborting, dropErr;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  int phase = 0;

  // reference model state: 0 idle, 1 wait, 2 tx, 3 abort, 4 retry wait
  int mSt = 0;
  int mBuf = 0;
  bit mDone = 0, mErr = 0, mRst = 0;
  bit tickAt = 0;
  bit lastGo = 0;

  always #10 clk = ~clk;  // 50 MHz

  dca_access_ctrl u_dut (
    .clk(clk), .rstN(rstN), .frameTick(frameTick), .useGrant(useGrant),
    .ciCh2(ciCh2), .grantIn(grantIn), .txReq(txReq), .bufAdvance(bufAdvance),
    .txDone(txDone), .txBit(txBit), .dOut(dOut), .txGo(txGo),
    .txRestart(txRestart), .aborting(aborting), .dropErr(dropErr)
  );

  task automatic chk(string tag, logic act, logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %0b expected %0b", tag, $time, act, exp);
    end
  endtask

  // frame-boundary strobe, every 4 clocks
  always @(negedge clk) begin
    #2;
    phase = (phase + 1) % 4;
    frameTick = (phase == 0);
  end

  // behavioural reference, stepped on each rising edge
  always @(posedge clk) begin
    bit free, pend, clrB;
    int nSt, nBuf;
    bit nErr, nRst;
    tickAt = frameTick;
    if (!rstN) begin
      mSt = 0; mBuf = 0; mDone = 0; mErr = 0; mRst = 0;
    end else begin
      free = useGrant ? grantIn : !ciCh2[4];
      pend = mDone || (txDone && mSt == 2);
      nSt = mSt; nBuf = mBuf; nErr = mErr; nRst = 0; clrB = 0;
      if (frameTick) begin
        case (mSt)
          0: if (txReq) begin nSt = 1; nErr = 0; end
          1: if (free) begin nSt = 2; clrB = 1; end
          2: if (pend) nSt = 0;
             else if (!free) begin
               if (mBuf < 2) nSt = 3;
               else begin nSt = 0; nErr = 1; end
             end
          3: nSt = 4;
          4: if (free) begin nSt = 2; clrB = 1; nRst = 1; end
          default: nSt = 0;
        endcase
      end
      if (clrB) nBuf = 0;
      else if (bufAdvance && mSt == 2 && mBuf < 2) nBuf = mBuf + 1;
      mDone = frameTick ? 1'b0 : pend;
      mSt = nSt; mBuf = nBuf; mErr = nErr; mRst = nRst;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    cycles++;
    chk("R4 txGo", txGo, mSt == 2);
    chk("R5 dOut", dOut, (mSt == 2) ? txBit : 1'b1);
    chk("R6 aborting", aborting, mSt == 3);
    chk("R7 txRestart", txRestart, mRst);
    chk("R8 dropErr", dropErr, mErr);
    if (rstN && txGo !== lastGo && !tickAt) begin
      compared++; mismatched++;
      $display("FAIL R2 txGo moved without tick: actual %0b expected %0b", txGo, lastGo);
    end
    lastGo = txGo;
    if (cycles > 150000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic wcyc(int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic frames(int n);
    wcyc(4 * n);
  endtask

  task automatic advPulse();
    bufAdvance = 1'b1; wcyc(1); bufAdvance = 1'b0; wcyc(1);
  endtask

  task automatic startFrame();
    txReq = 1'b1; frames(3); txReq = 1'b0;
  endtask

  initial begin
    wcyc(3);
    chk("R1 reset txGo", txGo, 1'b0);
    chk("R1 reset dOut", dOut, 1'b1);
    chk("R1 reset dropErr", dropErr, 1'b0);
    rstN = 1'b1;
    wcyc(2);

    // R3: C/I source, busy then free with other bits set
    ciCh2 = 6'b010000;
    txReq = 1'b1; frames(3);
    chk("R3 busy bit holds off", txGo, 1'b0);
    ciCh2 = 6'b101111;
    frames(2); txReq = 1'b0;
    chk("R3 free with bit4 low", txGo, 1'b1);
    txBit = 1'b0; wcyc(1);
    chk("R5 data passes", dOut, 1'b0);
    txDone = 1'b1; wcyc(1); txDone = 1'b0;
    frames(2);
    chk("R10 done ends frame", txGo, 1'b0);

    // R6/R7/R11: collision after one buffer, retry, collide again
    startFrame();
    advPulse();
    ciCh2 = 6'b010000; frames(1);
    chk("R6 early collision no drop", dropErr, 1'b0);
    frames(2);
    ciCh2 = 6'b000000; frames(2);
    chk("R7 retried", txGo, 1'b1);
    advPulse();
    ciCh2 = 6'b010000; frames(3);
    chk("R11 count reset, still retry", dropErr, 1'b0);
    ciCh2 = 6'b000000; frames(2);
    chk("R11 resumes again", txGo, 1'b1);

    // R8: late collision drops
    advPulse(); advPulse();
    ciCh2 = 6'b010000; frames(2);
    chk("R8 drop flag", dropErr, 1'b1);
    ciCh2 = 6'b000000; frames(3);
    chk("R8 no retry", txGo, 1'b0);
    chk("R9 sticky", dropErr, 1'b1);
    txReq = 1'b1; frames(2); txReq = 1'b0;
    chk("R9 cleared on accept", dropErr, 1'b0);
    frames(2);

    // R10: done and collision together
    ciCh2 = 6'b010000; txDone = 1'b1; wcyc(1); txDone = 1'b0;
    frames(2);
    ciCh2 = 6'b000000; frames(3);
    chk("R10 done beats collision", txGo, 1'b0);

    // R3: grant source
    useGrant = 1'b1; grantIn = 1'b0; ciCh2 = 6'b000000;
    txReq = 1'b1; frames(3);
    chk("R3 grant low holds off", txGo, 1'b0);
    grantIn = 1'b1; frames(2); txReq = 1'b0;
    chk("R3 grant high frees", txGo, 1'b1);
    grantIn = 1'b0; frames(2);
    chk("R6 grant collision aborts", dropErr, 1'b0);
    grantIn = 1'b1; frames(3);

    // random phase, model compared every cycle
    for (int i = 0; i < 4000; i++) begin
      txReq      = ($urandom % 4) != 0;
      ciCh2      = 6'($urandom);
      grantIn    = ($urandom % 3) != 0;
      bufAdvance = ($urandom % 6) == 0;
      txDone     = ($urandom % 12) == 0;
      txBit      = 1'($urandom);
      if ($urandom % 200 == 0) useGrant = ~useGrant;
      wcyc(1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule